// File: doc/BRIEF.md
# Secure Memory Block Cipher Controller

This block runs a 64-bit block transform over two on-chip buffers: a plaintext store (red) and a ciphertext store (black). Software fills the buffers through a 32-bit register bus. It then sets a start block in each buffer, a block count, an optional chaining value and a mode word. The controller walks the blocks one at a time in ECB or CBC order, in either direction. When it finishes it raises an interrupt. The transform itself is a stand-in. With a 32-bit key K, encryption is E(x) = rotate_left_13(x XOR {K, ~K}) and decryption is its inverse.

Encryption reads red and writes black, and decryption reads black and writes red, so the two buffers swap roles with direction. In CBC mode the chaining value left in the IV registers after a run is the last ciphertext block. A following request can therefore continue the same chain without software help.

Top module: `smc_cipher_ctrl`

## Requirements
- R1: After reset, the status word reads 0 and `irq` is low. The configuration word at byte offset 0x18 reads bytes-per-block in bits 6:0, red blocks in bits 16:7 and black blocks in bits 26:17, which is 0x00802008 with the default parameters.
- R2: ECB encryption. Writing control (offset 0x0C) with bit 2 set, bit 1 clear and bit 0 clear turns block i into E(red block rb+i) and writes it to black block bb+i. rb is the red start register (offset 0x00) and bb is the black start register (offset 0x04), both in block units. Block b occupies window words 2b (bits 31:0) and 2b+1 (bits 63:32). The red window starts at byte 0x400 and the black window at byte 0x800.
- R3: ECB decryption (control bit 0 set) writes D(black block bb+i) to red block rb+i.
- R4: CBC encryption (control bit 1 set) computes c_i = E(p_i XOR c_(i-1)), with c_(-1) taken from the IV registers (low word at 0x1C, high word at 0x20). At completion the IV registers hold the last c_i.
- R5: CBC decryption computes p_i = D(c_i) XOR c_(i-1). At completion the IV registers hold the last ciphertext block that was read.
- R6: The length register (offset 0x08) holds the block count minus one. Only the addressed blocks change. A single block at the last block index is processed.
- R7: If start plus count exceeds the buffer size in either buffer, a start request sets status bit 12, does not run and changes no memory. The next accepted start clears bit 12.
- R8: While the block is busy, writes to every register except interrupt control are ignored, so a second start has no effect.
- R9: Completion sets status bit 10 and the pending bit 8. `irq` equals pending AND NOT mask, where the mask is bit 0 of interrupt control (offset 0x14). Writing bit 1 of interrupt control clears pending and both done bits.
- R10: Writing bit 2 of interrupt control while idle clears every word of both buffers. Zeroising shows in status bit 1; when it ends, status bit 9 and pending are set.
- R11: While a run is active, status bits 0 (busy) and 2 (ciphering) are set, and bus accesses to either buffer are ignored: writes are dropped and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address: registers below 0x400, red window at 0x400, black window at 0x800 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench checks that the chain runs across a multi-block CBC run and ends in the IV registers in both directions. A design that kept the plaintext as the chaining value, or left the IV untouched, would produce wrong second blocks or a wrong readback. It checks both buffer ends: a one-block run at the last index must succeed, while runs that cross the end of either buffer must be refused with memory unchanged. An off-by-one in the range check fails one side or the other. During a full 64-block run, it tries a second start, a register write and a buffer write. A design that let any of them through would corrupt the final ciphertext or the red start register. Masked completion, interrupt clearing and zeroisation are checked last, through the status and interrupt pins.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int XF_ROT = 13;

  // register word indices (byte offset / 4)
  localparam logic [3:0] RI_RED_BASE = 4'd0;
  localparam logic [3:0] RI_BLK_BASE = 4'd1;
  localparam logic [3:0] RI_LEN      = 4'd2;
  localparam logic [3:0] RI_CTRL     = 4'd3;
  localparam logic [3:0] RI_STAT     = 4'd4;
  localparam logic [3:0] RI_IRQ      = 4'd5;
  localparam logic [3:0] RI_CFG      = 4'd6;
  localparam logic [3:0] RI_IV_LO    = 4'd7;
  localparam logic [3:0] RI_IV_HI    = 4'd8;
  localparam logic [3:0] RI_KEY      = 4'd9;

  localparam int CB_DEC = 0, CB_CBC = 1, CB_START = 2;
  localparam int SB_BUSY = 0, SB_ZEROING = 1, SB_CIPH = 2, SB_PEND = 8;
  localparam int SB_ZDONE = 9, SB_CDONE = 10, SB_LENERR = 12;
  localparam int IB_MASK = 0, IB_CLR = 1, IB_ZERO = 2;

  typedef enum logic [3:0] {
    ES_IDLE, ES_RDLO, ES_RDHI, ES_CAP, ES_PACE, ES_WRLO, ES_WRHI, ES_ZERO
  } smc_state_e;

  typedef enum logic [1:0] {RS_NONE, RS_REG, RS_RED, RS_BLK} smc_rsel_e;

  function automatic logic [63:0] xf_fwd(input logic [63:0] x, input logic [31:0] k);
    logic [63:0] t;
    t = x ^ {k, ~k};
    return (t << XF_ROT) | (t >> (64 - XF_ROT));
  endfunction

  function automatic logic [63:0] xf_inv(input logic [63:0] y, input logic [31:0] k);
    logic [63:0] t;
    t = (y >> XF_ROT) | (y << (64 - XF_ROT));
    return t ^ {k, ~k};
  endfunction
endpackage

// File: rtl/smc_word_ram.sv
module smc_word_ram #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/smc_engine.sv
module smc_engine
  import smc_pkg::*;
#(
  parameter int NBLK         = 64,
  parameter int BLOCK_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       zero_i,
  input  logic                       dec_i,
  input  logic                       cbc_i,
  input  logic [$clog2(NBLK)-1:0]    red_base_i,
  input  logic [$clog2(NBLK)-1:0]    blk_base_i,
  input  logic [$clog2(NBLK)-1:0]    len_m1_i,
  input  logic [31:0]                key_i,
  input  logic [63:0]                iv_i,
  output logic                       ciph_busy_o,
  output logic                       zero_busy_o,
  output logic                       ciph_done_o,
  output logic                       zero_done_o,
  output logic [63:0]                chain_o,
  output logic                       red_en_o,
  output logic                       red_we_o,
  output logic [$clog2(NBLK):0]      red_addr_o,
  output logic [31:0]                red_wdata_o,
  input  logic [31:0]                red_rdata_i,
  output logic                       blk_en_o,
  output logic                       blk_we_o,
  output logic [$clog2(NBLK):0]      blk_addr_o,
  output logic [31:0]                blk_wdata_o,
  input  logic [31:0]                blk_rdata_i
);
  localparam int BAW  = $clog2(NBLK);
  localparam int WAW  = BAW + 1;
  localparam int PACE = BLOCK_CYCLES - 5;
  localparam int PCW  = $clog2(BLOCK_CYCLES + 1);

  smc_state_e       state_q;
  logic             dec_q, cbc_q;
  logic [31:0]      key_q;
  logic [BAW-1:0]   len_q, idx_q, src_q, dst_q;
  logic [WAW-1:0]   zaddr_q;
  logic [PCW-1:0]   pace_q;
  logic [31:0]      lo_q;
  logic [63:0]      res_q, chain_q;

  logic [31:0] src_rdata;
  logic [63:0] blk_in, res_c, chain_c, core_out;

  always_comb begin
    src_rdata = dec_q ? blk_rdata_i : red_rdata_i;
    blk_in    = {src_rdata, lo_q};
    if (!dec_q) begin
      core_out = xf_fwd(cbc_q ? (blk_in ^ chain_q) : blk_in, key_q);
      res_c    = core_out;
      chain_c  = core_out;
    end else begin
      core_out = xf_inv(blk_in, key_q);
      res_c    = cbc_q ? (core_out ^ chain_q) : core_out;
      chain_c  = blk_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ES_IDLE;
      dec_q       <= 1'b0;
      cbc_q       <= 1'b0;
      key_q       <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      zaddr_q     <= '0;
      pace_q      <= '0;
      lo_q        <= '0;
      res_q       <= '0;
      chain_q     <= '0;
      ciph_done_o <= 1'b0;
      zero_done_o <= 1'b0;
    end else begin
      ciph_done_o <= 1'b0;
      zero_done_o <= 1'b0;
      case (state_q)
        ES_IDLE: begin
          if (start_i) begin
            dec_q   <= dec_i;
            cbc_q   <= cbc_i;
            key_q   <= key_i;
            len_q   <= len_m1_i;
            idx_q   <= '0;
            chain_q <= iv_i;
            src_q   <= dec_i ? blk_base_i : red_base_i;
            dst_q   <= dec_i ? red_base_i : blk_base_i;
            state_q <= ES_RDLO;
          end else if (zero_i) begin
            zaddr_q <= '0;
            state_q <= ES_ZERO;
          end
        end
        ES_RDLO: state_q <= ES_RDHI;
        ES_RDHI: begin
          lo_q    <= src_rdata;
          state_q <= ES_CAP;
        end
        ES_CAP: begin
          res_q   <= res_c;
          if (cbc_q) chain_q <= chain_c;
          pace_q  <= '0;
          state_q <= (PACE == 0) ? ES_WRLO : ES_PACE;
        end
        ES_PACE: begin
          pace_q <= pace_q + PCW'(1);
          if (pace_q == PCW'(PACE - 1)) state_q <= ES_WRLO;
        end
        ES_WRLO: state_q <= ES_WRHI;
        ES_WRHI: begin
          if (idx_q == len_q) begin
            state_q     <= ES_IDLE;
            ciph_done_o <= 1'b1;
          end else begin
            idx_q   <= idx_q + BAW'(1);
            src_q   <= src_q + BAW'(1);
            dst_q   <= dst_q + BAW'(1);
            state_q <= ES_RDLO;
          end
        end
        ES_ZERO: begin
          zaddr_q <= zaddr_q + WAW'(1);
          if (zaddr_q == {WAW{1'b1}}) begin
            state_q     <= ES_IDLE;
            zero_done_o <= 1'b1;
          end
        end
        default: state_q <= ES_IDLE;
      endcase
    end
  end

  logic rd_phase, wr_phase;
  always_comb begin
    rd_phase    = (state_q == ES_RDLO) || (state_q == ES_RDHI);
    wr_phase    = (state_q == ES_WRLO) || (state_q == ES_WRHI);
    red_en_o    = 1'b0;
    red_we_o    = 1'b0;
    red_addr_o  = '0;
    red_wdata_o = '0;
    blk_en_o    = 1'b0;
    blk_we_o    = 1'b0;
    blk_addr_o  = '0;
    blk_wdata_o = '0;
    if (rd_phase) begin
      if (dec_q) begin
        blk_en_o   = 1'b1;
        blk_addr_o = {src_q, state_q == ES_RDHI};
      end else begin
        red_en_o   = 1'b1;
        red_addr_o = {src_q, state_q == ES_RDHI};
      end
    end else if (wr_phase) begin
      if (dec_q) begin
        red_en_o    = 1'b1;
        red_we_o    = 1'b1;
        red_addr_o  = {dst_q, state_q == ES_WRHI};
        red_wdata_o = (state_q == ES_WRHI) ? res_q[63:32] : res_q[31:0];
      end else begin
        blk_en_o    = 1'b1;
        blk_we_o    = 1'b1;
        blk_addr_o  = {dst_q, state_q == ES_WRHI};
        blk_wdata_o = (state_q == ES_WRHI) ? res_q[63:32] : res_q[31:0];
      end
    end else if (state_q == ES_ZERO) begin
      red_en_o   = 1'b1;
      red_we_o   = 1'b1;
      red_addr_o = zaddr_q;
      blk_en_o   = 1'b1;
      blk_we_o   = 1'b1;
      blk_addr_o = zaddr_q;
    end
  end

  assign ciph_busy_o = (state_q != ES_IDLE) && (state_q != ES_ZERO);
  assign zero_busy_o = (state_q == ES_ZERO);
  assign chain_o     = chain_q;
endmodule

// File: rtl/smc_cipher_ctrl.sv
module smc_cipher_ctrl
  import smc_pkg::*;
#(
  parameter int NBLK         = 64,
  parameter int BLOCK_BYTES  = 8,
  parameter int BLOCK_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq
);
  localparam int BAW = $clog2(NBLK);
  localparam int WAW = BAW + 1;
  localparam logic [31:0] CFG_WORD = 32'(BLOCK_BYTES) | (32'(NBLK) << 7) | (32'(NBLK) << 17);

  // ---------------- bus decode ----------------
  logic [9:0]     waddr;
  logic           aligned, reg_hit, red_hit, blk_hit;
  logic [3:0]     reg_idx;
  logic [WAW-1:0] mem_word;

  assign waddr    = bus_addr[11:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign reg_idx  = waddr[3:0];
  assign mem_word = waddr[WAW-1:0];
  assign reg_hit  = aligned && (waddr[9:8] == 2'b00) && (waddr[7:4] == 4'd0);
  assign red_hit  = aligned && (waddr[9:8] == 2'b01) && ((waddr[7:0] >> WAW) == 8'd0);
  assign blk_hit  = aligned && (waddr[9:8] == 2'b10) && ((waddr[7:0] >> WAW) == 8'd0);

  // ---------------- state ----------------
  logic [BAW-1:0] red_base_q, blk_base_q, len_q;
  logic           dec_q, cbc_q;
  logic [63:0]    iv_q;
  logic [31:0]    key_q;
  logic           mask_q, pend_q, cdone_q, zdone_q, lenerr_q;
  logic           eng_start_q, eng_zero_q, irq_q;
  logic           mask_n, pend_n;

  logic           eng_ciph_busy, eng_zero_busy, eng_ciph_done, eng_zero_done;
  logic [63:0]    eng_chain;
  logic           busy;
  logic           reg_wr;

  assign busy   = eng_ciph_busy | eng_zero_busy | eng_start_q | eng_zero_q;
  assign reg_wr = bus_req && bus_we && reg_hit;

  // range check: start + count must not pass either buffer end
  logic [BAW:0] red_end, blk_end;
  logic         range_bad;
  always_comb begin
    red_end   = {1'b0, red_base_q} + {1'b0, len_q} + (BAW+1)'(1);
    blk_end   = {1'b0, blk_base_q} + {1'b0, len_q} + (BAW+1)'(1);
    range_bad = (red_end > (BAW+1)'(NBLK)) || (blk_end > (BAW+1)'(NBLK));
  end

  always_comb begin
    mask_n = mask_q;
    pend_n = pend_q;
    if (reg_wr && reg_idx == RI_IRQ) begin
      mask_n = bus_wdata[IB_MASK];
      if (bus_wdata[IB_CLR]) pend_n = 1'b0;
    end
    if (eng_ciph_done || eng_zero_done) pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      red_base_q  <= '0;
      blk_base_q  <= '0;
      len_q       <= '0;
      dec_q       <= 1'b0;
      cbc_q       <= 1'b0;
      iv_q        <= '0;
      key_q       <= '0;
      mask_q      <= 1'b0;
      pend_q      <= 1'b0;
      cdone_q     <= 1'b0;
      zdone_q     <= 1'b0;
      lenerr_q    <= 1'b0;
      eng_start_q <= 1'b0;
      eng_zero_q  <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      eng_start_q <= 1'b0;
      eng_zero_q  <= 1'b0;
      mask_q      <= mask_n;
      pend_q      <= pend_n;
      irq_q       <= pend_n & ~mask_n;
      if (reg_wr && !busy) begin
        case (reg_idx)
          RI_RED_BASE: red_base_q <= bus_wdata[BAW-1:0];
          RI_BLK_BASE: blk_base_q <= bus_wdata[BAW-1:0];
          RI_LEN:      len_q      <= bus_wdata[BAW-1:0];
          RI_IV_LO:    iv_q[31:0]  <= bus_wdata;
          RI_IV_HI:    iv_q[63:32] <= bus_wdata;
          RI_KEY:      key_q      <= bus_wdata;
          RI_CTRL: begin
            dec_q <= bus_wdata[CB_DEC];
            cbc_q <= bus_wdata[CB_CBC];
            if (bus_wdata[CB_START]) begin
              if (range_bad) begin
                lenerr_q <= 1'b1;
              end else begin
                lenerr_q    <= 1'b0;
                cdone_q     <= 1'b0;
                eng_start_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      if (reg_wr && reg_idx == RI_IRQ) begin
        if (bus_wdata[IB_CLR]) begin
          cdone_q <= 1'b0;
          zdone_q <= 1'b0;
        end
        if (bus_wdata[IB_ZERO] && !busy) begin
          eng_zero_q <= 1'b1;
          zdone_q    <= 1'b0;
        end
      end
      if (eng_ciph_done) begin
        cdone_q <= 1'b1;
        if (cbc_q) iv_q <= eng_chain;
      end
      if (eng_zero_done) zdone_q <= 1'b1;
    end
  end

  assign irq = irq_q;

  // ---------------- engine and buffers ----------------
  logic           e_red_en, e_red_we, e_blk_en, e_blk_we;
  logic [WAW-1:0] e_red_addr, e_blk_addr;
  logic [31:0]    e_red_wdata, e_blk_wdata;
  logic [31:0]    red_rdata, blk_rdata;

  smc_engine #(.NBLK(NBLK), .BLOCK_CYCLES(BLOCK_CYCLES)) engine_i (
    .clk(clk), .rst(rst),
    .start_i(eng_start_q), .zero_i(eng_zero_q),
    .dec_i(dec_q), .cbc_i(cbc_q),
    .red_base_i(red_base_q), .blk_base_i(blk_base_q), .len_m1_i(len_q),
    .key_i(key_q), .iv_i(iv_q),
    .ciph_busy_o(eng_ciph_busy), .zero_busy_o(eng_zero_busy),
    .ciph_done_o(eng_ciph_done), .zero_done_o(eng_zero_done),
    .chain_o(eng_chain),
    .red_en_o(e_red_en), .red_we_o(e_red_we), .red_addr_o(e_red_addr),
    .red_wdata_o(e_red_wdata), .red_rdata_i(red_rdata),
    .blk_en_o(e_blk_en), .blk_we_o(e_blk_we), .blk_addr_o(e_blk_addr),
    .blk_wdata_o(e_blk_wdata), .blk_rdata_i(blk_rdata)
  );

  logic           m_red_en, m_red_we, m_blk_en, m_blk_we;
  logic [WAW-1:0] m_red_addr, m_blk_addr;
  logic [31:0]    m_red_wdata, m_blk_wdata;
  logic           eng_owns;

  assign eng_owns = eng_ciph_busy | eng_zero_busy;

  always_comb begin
    if (eng_owns) begin
      m_red_en = e_red_en;  m_red_we = e_red_we;  m_red_addr = e_red_addr;  m_red_wdata = e_red_wdata;
      m_blk_en = e_blk_en;  m_blk_we = e_blk_we;  m_blk_addr = e_blk_addr;  m_blk_wdata = e_blk_wdata;
    end else begin
      m_red_en    = bus_req && red_hit && !busy;
      m_red_we    = bus_we;
      m_red_addr  = mem_word;
      m_red_wdata = bus_wdata;
      m_blk_en    = bus_req && blk_hit && !busy;
      m_blk_we    = bus_we;
      m_blk_addr  = mem_word;
      m_blk_wdata = bus_wdata;
    end
  end

  smc_word_ram #(.DW(32), .AW(WAW)) red_ram_i (
    .clk(clk), .en(m_red_en), .we(m_red_we), .addr(m_red_addr),
    .wdata(m_red_wdata), .rdata(red_rdata)
  );

  smc_word_ram #(.DW(32), .AW(WAW)) blk_ram_i (
    .clk(clk), .en(m_blk_en), .we(m_blk_we), .addr(m_blk_addr),
    .wdata(m_blk_wdata), .rdata(blk_rdata)
  );

  // ---------------- read path ----------------
  logic [31:0] stat_word, reg_rd_c, reg_rd_q;
  smc_rsel_e   rsel_q;

  always_comb begin
    stat_word             = '0;
    stat_word[SB_BUSY]    = eng_ciph_busy | eng_zero_busy;
    stat_word[SB_ZEROING] = eng_zero_busy;
    stat_word[SB_CIPH]    = eng_ciph_busy;
    stat_word[SB_PEND]    = pend_q;
    stat_word[SB_ZDONE]   = zdone_q;
    stat_word[SB_CDONE]   = cdone_q;
    stat_word[SB_LENERR]  = lenerr_q;
    case (reg_idx)
      RI_RED_BASE: reg_rd_c = 32'(red_base_q);
      RI_BLK_BASE: reg_rd_c = 32'(blk_base_q);
      RI_LEN:      reg_rd_c = 32'(len_q);
      RI_CTRL:     reg_rd_c = {29'd0, eng_ciph_busy, cbc_q, dec_q};
      RI_STAT:     reg_rd_c = stat_word;
      RI_IRQ:      reg_rd_c = {31'd0, mask_q};
      RI_CFG:      reg_rd_c = CFG_WORD;
      RI_IV_LO:    reg_rd_c = iv_q[31:0];
      RI_IV_HI:    reg_rd_c = iv_q[63:32];
      RI_KEY:      reg_rd_c = key_q;
      default:     reg_rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      rsel_q     <= RS_NONE;
      reg_rd_q   <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      reg_rd_q   <= reg_rd_c;
      if (reg_hit)                rsel_q <= RS_REG;
      else if (red_hit && !busy)  rsel_q <= RS_RED;
      else if (blk_hit && !busy)  rsel_q <= RS_BLK;
      else                        rsel_q <= RS_NONE;
    end
  end

  always_comb begin
    case (rsel_q)
      RS_REG:  bus_rdata = reg_rd_q;
      RS_RED:  bus_rdata = red_rdata;
      RS_BLK:  bus_rdata = blk_rdata;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smc_cipher_ctrl_chk.sv
module smc_cipher_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic mask_q,
  input logic pend_q,
  input logic lenerr_q,
  input logic ciph_busy,
  input logic zero_busy,
  input logic start_q,
  input logic cdone_q
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) mask_q |-> !irq); // R9
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst) irq |-> pend_q); // R9
  AST_LENERR_NO_RUN: assert property (@(posedge clk) disable iff (rst) $rose(lenerr_q) |-> (!ciph_busy && !start_q)); // R7
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst) $fell(ciph_busy) |=> cdone_q); // R9
  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst) $rose(ciph_busy) |-> $past(start_q)); // R8
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(ciph_busy && zero_busy)); // R10
endmodule

bind smc_cipher_ctrl smc_cipher_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .irq(irq), .mask_q(mask_q), .pend_q(pend_q),
  .lenerr_q(lenerr_q), .ciph_busy(eng_ciph_busy), .zero_busy(eng_zero_busy),
  .start_q(eng_start_q), .cdone_q(cdone_q)
);

// File: tb/smc_cipher_ctrl_tb_top.sv
module smc_cipher_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  smc_cipher_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  localparam logic [31:0] KEY = 32'hC0DE_5EED;
  localparam logic [63:0] IV0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [11:0] A_RB = 12'h000, A_BB = 12'h004, A_LEN = 12'h008, A_CTRL = 12'h00C;
  localparam logic [11:0] A_STAT = 12'h010, A_IRQ = 12'h014, A_CFG = 12'h018;
  localparam logic [11:0] A_IVL = 12'h01C, A_IVH = 12'h020, A_KEY = 12'h024;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] red_m [128];
  logic [31:0] blk_m [128];
  logic [63:0] iv_m;

  typedef struct { logic [11:0] addr; logic [31:0] data; string tag; } exp_t;
  exp_t sb_q[$];

  function automatic logic [63:0] m_enc(input logic [63:0] x);
    logic [63:0] t;
    t = x ^ {KEY, ~KEY};
    return {t[50:0], t[63:51]};
  endfunction
  function automatic logic [63:0] m_dec(input logic [63:0] y);
    logic [63:0] t;
    t = {y[12:0], y[63:13]};
    return t ^ {KEY, ~KEY};
  endfunction
  function automatic logic [31:0] pat(input int w);
    return 32'h5A5A_0000 ^ (32'(w) * 32'h0003_0101 + 32'h1000_0007);
  endfunction
  function automatic logic [11:0] red_a(input int w); return 12'h400 + 12'(w * 4); endfunction
  function automatic logic [11:0] blk_a(input int w); return 12'h800 + 12'(w * 4); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [11:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.addr = a; e.data = d; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops each expected item and compares it with the design's buffer
  task automatic drain();
    logic [31:0] v;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      rd(e.addr, v);
      check(e.tag, v, e.data);
    end
  endtask

  task automatic wait_stat(input int bitpos, input string tag);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, s);
      if (s[bitpos]) return;
    end
    check(tag, 32'h0, 32'h1);
  endtask

  task automatic start_op(input int rb, input int bb, input int n, input bit dec, input bit cbc);
    wr(A_RB, 32'(rb));
    wr(A_BB, 32'(bb));
    wr(A_LEN, 32'(n - 1));
    wr(A_CTRL, {29'd0, 1'b1, cbc, dec});
  endtask

  // driver side: computes expected results and pushes the whole destination buffer
  task automatic finish_op(input int rb, input int bb, input int n, input bit dec, input bit cbc,
                           input string tag);
    logic [63:0] chain, x, y;
    logic [31:0] v;
    wait_stat(10, tag);
    chain = iv_m;
    for (int i = 0; i < n; i++) begin
      if (!dec) begin
        x = {red_m[2*(rb+i)+1], red_m[2*(rb+i)]};
        y = m_enc(cbc ? (x ^ chain) : x);
        chain = y;
        blk_m[2*(bb+i)] = y[31:0]; blk_m[2*(bb+i)+1] = y[63:32];
      end else begin
        x = {blk_m[2*(bb+i)+1], blk_m[2*(bb+i)]};
        y = m_dec(x);
        if (cbc) y = y ^ chain;
        chain = x;
        red_m[2*(rb+i)] = y[31:0]; red_m[2*(rb+i)+1] = y[63:32];
      end
    end
    for (int w = 0; w < 128; w++) begin
      if (!dec) push(blk_a(w), blk_m[w], tag);
      else      push(red_a(w), red_m[w], tag);
    end
    drain();
    if (cbc) begin
      iv_m = chain;
      rd(A_IVL, v); check({tag, " iv lo"}, v, chain[31:0]);
      rd(A_IVH, v); check({tag, " iv hi"}, v, chain[63:32]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state and configuration word
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(A_CFG, v);  check("R1 cfg", v, 32'h0080_2008);

    for (int w = 0; w < 128; w++) begin
      wr(red_a(w), pat(w));  red_m[w] = pat(w);
      wr(blk_a(w), ~pat(w)); blk_m[w] = ~pat(w);
    end
    wr(A_KEY, KEY);
    iv_m = '0;

    // R2: ECB encrypt, three blocks
    start_op(4, 10, 3, 1'b0, 1'b0);
    finish_op(4, 10, 3, 1'b0, 1'b0, "R2 ecb enc");
    rd(A_STAT, v);
    check("R9 pending", 32'(v[8]), 32'h1);
    check("R9 irq high", 32'(irq), 32'h1);
    wr(A_IRQ, 32'h2);
    check("R9 irq cleared", 32'(irq), 32'h0);
    rd(A_STAT, v); check("R9 status cleared", v, 32'h0);

    // R3: ECB decrypt back into a different red region
    start_op(40, 10, 3, 1'b1, 1'b0);
    finish_op(40, 10, 3, 1'b1, 1'b0, "R3 ecb dec");
    wr(A_IRQ, 32'h2);

    // R4: CBC encrypt, four blocks
    wr(A_IVL, IV0[31:0]); wr(A_IVH, IV0[63:32]); iv_m = IV0;
    start_op(0, 20, 4, 1'b0, 1'b1);
    finish_op(0, 20, 4, 1'b0, 1'b1, "R4 cbc enc");
    wr(A_IRQ, 32'h2);

    // R5: CBC decrypt of that chain from the original IV
    wr(A_IVL, IV0[31:0]); wr(A_IVH, IV0[63:32]); iv_m = IV0;
    start_op(50, 20, 4, 1'b1, 1'b1);
    finish_op(50, 20, 4, 1'b1, 1'b1, "R5 cbc dec");
    wr(A_IRQ, 32'h2);

    // R6: single block (length 0) at the last block index
    start_op(63, 63, 1, 1'b0, 1'b0);
    finish_op(63, 63, 1, 1'b0, 1'b0, "R6 last block");
    wr(A_IRQ, 32'h2);

    // R7: red range overrun, then black range overrun
    start_op(60, 0, 5, 1'b0, 1'b0);
    rd(A_STAT, v);
    check("R7 red overrun lenerr", 32'(v[12]), 32'h1);
    check("R7 red overrun idle", 32'(v[0]), 32'h0);
    start_op(0, 62, 3, 1'b0, 1'b0);
    rd(A_STAT, v);
    check("R7 black overrun lenerr", 32'(v[12]), 32'h1);
    check("R7 black overrun no done", 32'(v[10]), 32'h0);
    for (int w = 0; w < 128; w++) push(blk_a(w), blk_m[w], "R7 black untouched");
    drain();

    // R8 / R11: full run with ignored start, register write and buffer write
    start_op(0, 0, 64, 1'b0, 1'b0);
    wr(A_CTRL, 32'h7);
    wr(A_RB, 32'd5);
    rd(A_STAT, v);
    check("R11 busy bit", 32'(v[0]), 32'h1);
    check("R11 ciphering bit", 32'(v[2]), 32'h1);
    check("R7 lenerr cleared by good start", 32'(v[12]), 32'h0);
    rd(blk_a(3), v); check("R11 buffer read while busy", v, 32'h0);
    wr(red_a(127), 32'hDEAD_BEEF);
    finish_op(0, 0, 64, 1'b0, 1'b0, "R8 second start ignored");
    rd(A_RB, v); check("R8 register write ignored", v, 32'h0);
    rd(red_a(127), v); check("R11 buffer write ignored", v, red_m[127]);
    wr(A_IRQ, 32'h2);

    // R9: masked completion
    wr(A_IRQ, 32'h1);
    start_op(1, 30, 1, 1'b0, 1'b0);
    finish_op(1, 30, 1, 1'b0, 1'b0, "R9 masked run");
    check("R9 irq masked", 32'(irq), 32'h0);
    rd(A_STAT, v); check("R9 pending while masked", 32'(v[8]), 32'h1);
    wr(A_IRQ, 32'h2);
    rd(A_STAT, v); check("R9 pending cleared", 32'(v[8]), 32'h0);
    check("R9 irq after clear", 32'(irq), 32'h0);

    // R10: zeroise both buffers
    wr(A_IRQ, 32'h4);
    wait_stat(9, "R10 zero done");
    rd(A_STAT, v);
    check("R10 pending", 32'(v[8]), 32'h1);
    check("R10 idle", 32'(v[1:0]), 32'h0);
    check("R10 irq", 32'(irq), 32'h1);
    for (int w = 0; w < 128; w++) begin
      push(red_a(w), 32'h0, "R10 red zero");
      push(blk_a(w), 32'h0, "R10 black zero");
    end
    drain();

    summary();
  end
endmodule